// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one timer channel that watches a free-running main counter and flags an interrupt when the counter reaches a programmable comparator value. The main counter advances by one on each tick-enable pulse while a global enable is set. Software can write the counter directly. The comparator is `CMP_W` bits wide, so one channel can be built as a narrow channel or as a full-width channel. Registers are written one bus word (`BUS_W` bits) at a time.

In one-shot mode the comparator stays where software put it. In periodic mode the channel keeps a separate period register, which holds the value software last wrote. Each match moves the comparator forward by that period, so reading the comparator always shows the next match point. A value-set control bit decides whether a comparator word write loads both the comparator and the period, or only the period. This lets software change the rate without disturbing the next match, or restart the schedule from a chosen point. The interrupt status is sticky. The output can be presented as a level or as a one-cycle pulse.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset the main counter is 0, the comparator is all ones, the status is 0, `irq` is 0, and every control bit is 0.
- R2: The main counter increments by exactly one at each clock edge where `tickEn` is 1 and the global enable (address 0, bit 0) is set. Otherwise it holds its value.
- R3: A write to address 8+i loads counter word i (bits i*BUS_W and up). This write wins over a tick in the same cycle, and no match is tested in that cycle.
- R4: The status sets at the edge where a tick moves the counter to a value whose low `CMP_W` bits equal the comparator. A comparator set behind the counter does not fire until the counter comes around to it.
- R5: In one-shot mode (channel control at address 1, bit 1 = 0), a match leaves the comparator unchanged. A write to address 4+i loads comparator word i directly.
- R6: When `CMP_W` < `CNT_W`, a one-shot channel also sets its status when a tick makes the low `CMP_W` bits of the counter wrap to 0. A channel with `CMP_W` = `CNT_W` does not.
- R7: In periodic mode each match replaces the comparator with the comparator plus the period, modulo 2^CMP_W. For example, 0xFF00 + 0x0200 gives 0x0100.
- R8: In periodic mode, a comparator word write made while value-set is 0 updates only that word of the period. The visible comparator is unchanged, and the new period applies from the next match.
- R9: The value-set bit (address 1, bit 2) makes the next comparator word write load both the comparator and the period. The bit then clears itself, so a wide value takes the sequence: set, write low word, set, write high word.
- R10: The status is sticky. Writing 1 to address 2 bit 0 clears it, and writing 0 there does not. A new match in the same cycle as a clear wins.
- R11: With channel-control bit 0 (interrupt enable) set, `irq` follows the status when bit 3 is 1 (level mode). When bit 3 is 0 (pulse mode), `irq` is high for the single cycle after each match edge. The interrupt enable masks only `irq` and never the status.
- R12: While the global enable is 0, the counter stands still, no status is set, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance request |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register word address |
| wrData | input | BUS_W | Register write data |
| mainCount | output | CNT_W | Main counter value |
| cmpValue | output | CMP_W | Comparator (next match point) |
| intStatus | output | 1 | Sticky interrupt status |
| irq | output | 1 | Interrupt output, level or pulse |

## Verification
Suppose the comparator accumulator or the period register holds a wrong value. The next match then lands on a different tick. Also, `cmpValue` shows the wrong next point in the very cycle after the match edge. A stuck or unexpected value-set bit shows up at the first comparator write, as a visible comparator that moves when it should hold, or holds when it should move. Errors in the status or output paths appear within one cycle of a match edge, on `intStatus` and `irq`.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int MAX_WORDS = 4;
  localparam logic [3:0] ADDR_GLOBAL   = 4'd0;
  localparam logic [3:0] ADDR_CTRL     = 4'd1;
  localparam logic [3:0] ADDR_STATUS   = 4'd2;
  localparam logic [3:0] ADDR_CMP_BASE = 4'd4;
  localparam logic [3:0] ADDR_CNT_BASE = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic                 tick;
    logic                 periodic;
    logic                 loadCmp;
    logic [MAX_WORDS-1:0] cmpWordSel;
    logic [MAX_WORDS-1:0] cntWordSel;
  } dpStrobe_t;
endpackage

// File: rtl/evt_timer_ctl.sv
module evt_timer_ctl
  import evt_timer_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int CMP_WORDS = 2,
  parameter int CNT_WORDS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [3:0]       wrAddr,
  input  logic [BUS_W-1:0] wrData,
  input  logic             fire,
  output dpStrobe_t        strobe,
  output logic             intStatus,
  output logic             irq
);
  logic globalEn, intEn, periodic, valueSet, levelMode, pulseReg;
  logic [MAX_WORDS-1:0] cmpSel, cntSel;
  logic ctrlWr, statusWr, globalWr;

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_sel
    if (i < CMP_WORDS) begin : g_cmp
      assign cmpSel[i] = wrEn && (wrAddr == ADDR_CMP_BASE + 4'(i));
    end else begin : g_nocmp
      assign cmpSel[i] = 1'b0;
    end
    if (i < CNT_WORDS) begin : g_cnt
      assign cntSel[i] = wrEn && (wrAddr == ADDR_CNT_BASE + 4'(i));
    end else begin : g_nocnt
      assign cntSel[i] = 1'b0;
    end
  end

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign statusWr = wrEn && (wrAddr == ADDR_STATUS);
  assign globalWr = wrEn && (wrAddr == ADDR_GLOBAL);

  always_comb begin
    strobe.tick       = globalEn && tickEn;
    strobe.periodic   = periodic;
    strobe.loadCmp    = valueSet || !periodic;
    strobe.cmpWordSel = cmpSel;
    strobe.cntWordSel = cntSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      intEn     <= 1'b0;
      periodic  <= 1'b0;
      valueSet  <= 1'b0;
      levelMode <= 1'b0;
      intStatus <= 1'b0;
      pulseReg  <= 1'b0;
    end else begin
      if (globalWr) globalEn <= wrData[0];
      if (ctrlWr) begin
        intEn     <= wrData[0];
        periodic  <= wrData[1];
        valueSet  <= wrData[2];
        levelMode <= wrData[3];
      end else if (valueSet && |cmpSel) begin
        valueSet <= 1'b0;
      end
      if (fire) intStatus <= 1'b1;
      else if (statusWr && wrData[0]) intStatus <= 1'b0;
      pulseReg <= fire && intEn;
    end
  end

  assign irq = globalEn && intEn && (levelMode ? intStatus : pulseReg);
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CMP_W = 64,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [BUS_W-1:0] wrData,
  output logic             fire,
  output logic [CNT_W-1:0] mainCount,
  output logic [CMP_W-1:0] cmpValue
);
  localparam int CMP_WORDS = CMP_W / BUS_W;
  localparam int CNT_WORDS = CNT_W / BUS_W;

  logic [CNT_W-1:0] countInc, countNext;
  logic [CMP_W-1:0] period, cmpNext, perNext;
  logic cntWrite, hit, wrapHit;

  assign countInc = mainCount + CNT_W'(1);
  assign cntWrite = |strobe.cntWordSel;
  assign hit = strobe.tick && !cntWrite && (countInc[CMP_W-1:0] == cmpValue);

  if (CMP_W < CNT_W) begin : g_wrap
    assign wrapHit = strobe.tick && !cntWrite && !strobe.periodic
                     && (countInc[CMP_W-1:0] == '0);
  end else begin : g_nowrap
    assign wrapHit = 1'b0;
  end

  assign fire = hit || wrapHit;

  always_comb begin
    countNext = mainCount;
    if (cntWrite) begin
      for (int i = 0; i < CNT_WORDS; i++)
        if (strobe.cntWordSel[i]) countNext[i*BUS_W +: BUS_W] = wrData;
    end else if (strobe.tick) begin
      countNext = countInc;
    end
  end

  always_comb begin
    cmpNext = cmpValue;
    perNext = period;
    if (hit && strobe.periodic) cmpNext = cmpValue + period;
    for (int i = 0; i < CMP_WORDS; i++) begin
      if (strobe.cmpWordSel[i]) begin
        perNext[i*BUS_W +: BUS_W] = wrData;
        if (strobe.loadCmp) cmpNext[i*BUS_W +: BUS_W] = wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCount <= '0;
      cmpValue  <= '1;
      period    <= '0;
    end else begin
      mainCount <= countNext;
      cmpValue  <= cmpNext;
      period    <= perNext;
    end
  end
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
  import evt_timer_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CMP_W = 64,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [3:0]       wrAddr,
  input  logic [BUS_W-1:0] wrData,
  output logic [CNT_W-1:0] mainCount,
  output logic [CMP_W-1:0] cmpValue,
  output logic             intStatus,
  output logic             irq
);
  localparam int CMP_WORDS = CMP_W / BUS_W;
  localparam int CNT_WORDS = CNT_W / BUS_W;

  dpStrobe_t strobe;
  logic fire;

  evt_timer_ctl #(.BUS_W(BUS_W), .CMP_WORDS(CMP_WORDS), .CNT_WORDS(CNT_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .fire(fire), .strobe(strobe), .intStatus(intStatus), .irq(irq)
  );

  evt_timer_dp #(.BUS_W(BUS_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .fire(fire),
    .mainCount(mainCount), .cmpValue(cmpValue)
  );
endmodule

// File: rtl/evt_timer_checker.sv
module evt_timer_checker #(
  parameter int BUS_W = 32,
  parameter int CMP_W = 64,
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             wrEn,
  input logic [3:0]       wrAddr,
  input logic [BUS_W-1:0] wrData,
  input logic [CNT_W-1:0] mainCount,
  input logic [CMP_W-1:0] cmpValue,
  input logic             intStatus,
  input logic             irq
);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !tickEn) |=> $stable(mainCount));

  assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !tickEn) |=> $stable(cmpValue));

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus && !(wrEn && wrAddr == 4'd2 && wrData[0])) |=> intStatus);

  assert_irq_needs_status_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intStatus);

  assert_status_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus) |-> $past(tickEn));
endmodule

bind evt_timer_channel evt_timer_checker #(.BUS_W(BUS_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .mainCount(mainCount), .cmpValue(cmpValue), .intStatus(intStatus), .irq(irq)
);

// File: tb/evt_timer_channel_test.sv
module evt_timer_channel_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [15:0] cntW, cntN, cmpW;
  logic [7:0] cmpN;
  logic stW, stN, irqW, irqN;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  // wide channel: comparator as wide as counter, split into two words
  evt_timer_channel #(.BUS_W(8), .CMP_W(16), .CNT_W(16)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mainCount(cntW), .cmpValue(cmpW), .intStatus(stW), .irq(irqW));
  // narrow channel: comparator narrower than counter
  evt_timer_channel #(.BUS_W(8), .CMP_W(8), .CNT_W(16)) uutNarrow (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mainCount(cntN), .cmpValue(cmpN), .intStatus(stN), .irq(irqN));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic tick(int n);
    if (n > 0) begin
      @(negedge clk); tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", cntW, 0);
    check("R1 cmp", cmpW, 16'hFFFF);
    check("R1 status", stW, 0);
    check("R1 irq", irqW, 0);
    // R12: no counting while globally disabled
    tick(5);
    check("R12 halted count", cntW, 0);
    // R2 counting
    wr(0, 8'h01);
    tick(10);
    check("R2 count", cntW, 16'h000A);
    check("R2 narrow count", cntN, 16'h000A);
    // R5 one-shot direct comparator load; level mode with interrupt enable
    wr(1, 8'b1001);
    wr(4, 8'h20); wr(5, 8'h00);
    check("R5 cmp load", cmpW, 16'h0020);
    tick(16'h15);
    check("R4 before match", stW, 0);
    tick(1);
    check("R4 match", stW, 1);
    check("R11 level irq", irqW, 1);
    check("R5 cmp unchanged", cmpW, 16'h0020);
    tick(3);
    check("R10 sticky", stW, 1);
    wr(2, 8'h01);
    check("R10 clear", stW, 0);
    check("R11 irq follows", irqW, 0);
    // R4: comparator behind counter
    wr(4, 8'h10); wr(5, 8'h00);
    tick(16'h20);
    check("R4 behind no fire", stW, 0);
    check("R6 narrow no fire", stN, 0);
    wr(8, 8'hF0); wr(9, 8'hFF);
    check("R3 count write", cntW, 16'hFFF0);
    tick(16'h10);
    check("R6 narrow wrap", stN, 1);
    check("R6 wide no wrap", stW, 0);
    tick(16'h10);
    check("R4 after wrap", stW, 1);
    // R9 value-set sequence in periodic mode
    wr(0, 8'h00); wr(2, 8'h01);
    wr(8, 8'h00); wr(9, 8'h00);
    wr(1, 8'b1111); wr(4, 8'h23);
    wr(5, 8'h01);
    check("R9 self-clear", cmpW, 16'h0023);
    wr(1, 8'b1111); wr(5, 8'h01);
    check("R9 split load", cmpW, 16'h0123);
    wr(0, 8'h01);
    // R7 periodic advance
    for (int m = 1; m <= 3; m++) begin
      tick(16'h122);
      check("R7 no early", stW, 0);
      tick(1);
      check("R7 match", stW, 1);
      check("R7 advance", cmpW, 32'((m + 1) * 16'h123));
      wr(2, 8'h01);
    end
    // R11 pulse mode
    wr(1, 8'b0011);
    tick(16'h122);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    check("R11 pulse high", irqW, 1);
    @(negedge clk);
    check("R11 pulse one cycle", irqW, 0);
    check("R11 status kept", stW, 1);
    wr(2, 8'h01);
    // R8 period change without value-set
    wr(4, 8'h10); wr(5, 8'h00);
    check("R8 cmp unchanged", cmpW, 16'h05AF);
    tick(16'h123);
    check("R8 new period", cmpW, 16'h05BF);
    wr(2, 8'h01);
    // R7 modulo wrap
    wr(0, 8'h00);
    wr(1, 8'b1111); wr(4, 8'h00);
    wr(1, 8'b1111); wr(5, 8'hFF);
    wr(4, 8'h00); wr(5, 8'h02);
    check("R8 period-only", cmpW, 16'hFF00);
    wr(8, 8'hF0); wr(9, 8'hFE);
    wr(0, 8'h01);
    tick(16'h10);
    check("R7 wrap add", cmpW, 16'h0100);
    wr(2, 8'h01);
    // R11 enable masks output only
    wr(1, 8'b1010);
    tick(16'h200);
    check("R11 masked status", stW, 1);
    check("R11 masked irq", irqW, 0);
    check("R7 next", cmpW, 16'h0300);
    wr(1, 8'b1011);
    check("R11 unmasked irq", irqW, 1);
    wr(0, 8'h00);
    check("R12 irq off", irqW, 0);
    tick(5);
    check("R12 count frozen", cntW, 16'h0100);
    wr(2, 8'h00);
    check("R10 write zero", stW, 1);
    // R3 write beats tick
    wr(0, 8'h01);
    @(negedge clk); wrEn = 1'b1; wrAddr = 4'd8; wrData = 8'h55; tickEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; tickEn = 1'b0;
    check("R3 write wins", cntW, 16'h0155);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule